// File: doc/BRIEF.md
# AES-128 Iterative Cipher Core

This block runs one 128-bit block through AES-128 encryption or decryption, one round per clock cycle. A single round datapath serves both directions. Decryption uses the equivalent inverse cipher, so the inverse operations run in the same order as the forward ones. The substitution boxes are built from arithmetic in GF(2^8): a multiplicative inverse plus an affine map. No table memory is used.

The round keys are not expanded inside the block. The core drives a round index, and a neighbouring key generator must return, without a register in between, the matching 128-bit round key on `round_key` in the same cycle. A start strobe accepted while the core is idle samples the data block and the direction. The key for index 0 is added at that moment. Rounds 1 to 10 then follow on the next ten clock edges. The result appears on a registered output together with a one-cycle done pulse.

Top module: `aes_iter_core`

## Requirements
- R1: While reset is high, and in the first cycle after it, `done` is 0, `round_idx` is 0 and `result` is all zeros.
- R2: A start strobe seen on a clock edge while the core is idle is accepted. On that edge the core stores `data_in` XOR `round_key`, with `round_key` answering index 0. `round_idx` then reads 1, 2, … 10 on the following cycles, one step per edge, and returns to 0 afterwards.
- R3: `done` is high for exactly one cycle. It rises 10 cycles after the accepting edge, on the edge that applies round 10. `result` changes only on that edge and holds its value until the next done.
- R4: With `decrypt`=0 the core encrypts. For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff the result is 69c4e0d86a7b0430d8cdb78070b4c55a. For key 2b7e151628aed2a6abf7158809cf4f3c and plaintext 3243f6a8885a308d313198a2e0370734 the result is 3925841d02dc09fbdc118597196a0b32.
- R5: With `decrypt`=1 the core decrypts by the equivalent inverse cipher. The key generator supplies the last expansion key at index 0 and the cipher key at index 10. At index i from 1 to 9 it supplies InvMixColumns of expansion key 10−i. Given those keys, the ciphertexts of R4 decrypt to their plaintexts.
- R6: Byte k of a 128-bit block sits in bits [127−8k : 120−8k]. Bytes fill the 4×4 state column by column, so byte k is row k mod 4, column k div 4. Rounds 1 to 9 apply (Inv)SubBytes, (Inv)ShiftRows, (Inv)MixColumns and the key XOR. Round 10 omits the column mix.
- R7: A start strobe while the core is busy is ignored. Changes on `data_in` and `decrypt` after the accepting edge do not affect the block in flight.
- R8: A start asserted in the cycle where `done` is high is accepted, so back-to-back blocks finish 11 cycles apart.
- R9: Encrypting any block and then decrypting the result under the same key returns the original block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a block when idle |
| decrypt | input | 1 | 1 = decrypt, 0 = encrypt; sampled at an accepted start |
| data_in | input | 128 | Input block, byte 0 in the top bits |
| round_key | input | 128 | Round key for the current `round_idx`, from the key generator |
| round_idx | output | 4 | Round whose key is needed now (0 to 10) |
| result | output | 128 | Output block, registered |
| done | output | 1 | One-cycle pulse when `result` is new |

## Verification
Two events can fall on the same clock edge: the last round finishing, which raises `done`, and the next block's start being accepted. The bench provokes this by asserting start in the very cycle it sees `done`. A behavioural model predicts, on every cycle, the index and done flag this must produce. The bench then checks that the second block starts at once, finishes 11 cycles after the first, and gives the known result. A start and a direction flip injected mid-block must leave both the index sequence and the result untouched.

// File: rtl/aes_pkg.sv
package aes_pkg;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, t;
    p = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = gf_x2(t);
    end
    return p;
  endfunction

  // x^254 is the multiplicative inverse; 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] x2, x3, x12, x15, x240, x252;
    x2   = gf_mul(x, x);
    x3   = gf_mul(x2, x);
    x12  = gf_mul(gf_mul(x3, x3), gf_mul(x3, x3));
    x15  = gf_mul(x12, x3);
    x240 = gf_mul(x15, x15);
    x240 = gf_mul(x240, x240);
    x240 = gf_mul(x240, x240);
    x240 = gf_mul(x240, x240);
    x252 = gf_mul(x240, x12);
    return gf_mul(x252, x2);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // one output byte of a column mix; row selects the coefficient rotation
  function automatic logic [7:0] mix_byte(input logic [31:0] col, input int row,
                                          input logic inv);
    logic [31:0] fwd, bwd;
    logic [7:0]  acc, cf;
    int k;
    fwd = 32'h02030101;
    bwd = 32'h0e0b0d09;
    acc = 8'h00;
    for (int j = 0; j < 4; j++) begin
      k   = (j - row + 4) % 4;
      cf  = inv ? bwd[31-8*k -: 8] : fwd[31-8*k -: 8];
      acc = acc ^ gf_mul(col[31-8*j -: 8], cf);
    end
    return acc;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_pkg::*;
(
  input  logic [7:0] din,
  input  logic       inv,
  output logic [7:0] dout
);
  logic [7:0] pre, post;

  always_comb begin
    if (inv) begin
      pre  = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ 8'h05;
      dout = gf_inv(pre);
      post = 8'h00;
    end else begin
      pre  = 8'h00;
      post = gf_inv(din);
      dout = post ^ rotl8(post, 1) ^ rotl8(post, 2) ^ rotl8(post, 3)
                  ^ rotl8(post, 4) ^ 8'h63;
    end
  end
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] state,
  input  logic [8*NB-1:0] rkey,
  input  logic            inv,
  input  logic            last,
  output logic [8*NB-1:0] nxt
);
  localparam int ROWS = 4;
  localparam int COLS = NB / ROWS;

  logic [7:0] st [NB];
  logic [7:0] sb [NB];
  logic [7:0] sh [NB];
  logic [7:0] mx [NB];

  for (genvar k = 0; k < NB; k++) begin : g_sub
    assign st[k] = state[8*NB-1-8*k -: 8];
    aes_sbox u_sb (.din(st[k]), .inv(inv), .dout(sb[k]));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign sh[c*ROWS+r] = inv ? sb[((c + COLS - r) % COLS)*ROWS + r]
                                : sb[((c + r) % COLS)*ROWS + r];
      assign mx[c*ROWS+r] = mix_byte({sh[c*ROWS], sh[c*ROWS+1], sh[c*ROWS+2],
                                      sh[c*ROWS+3]}, r, inv);
      assign nxt[8*NB-1-8*(c*ROWS+r) -: 8] =
        (last ? sh[c*ROWS+r] : mx[c*ROWS+r]) ^ rkey[8*NB-1-8*(c*ROWS+r) -: 8];
    end
  end
endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl #(
  parameter int ROUNDS = 10,
  localparam int IW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          accept,
  output logic          last,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST_IDX = IW'(ROUNDS);

  assign accept = start && !busy;
  assign last   = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      idx  <= IW'(1);
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

  // R2
  accept_load_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && idx == IW'(1)));
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (idx == '0));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && idx != LAST_IDX) |=> (idx == $past(idx) + IW'(1)));
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core #(
  parameter int ROUNDS = 10,
  parameter int NB = 16,
  localparam int IW = $clog2(ROUNDS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            decrypt,
  input  logic [8*NB-1:0] data_in,
  input  logic [8*NB-1:0] round_key,
  output logic [IW-1:0]   round_idx,
  output logic [8*NB-1:0] result,
  output logic            done
);
  localparam int BW = 8 * NB;

  logic          busy, accept, last;
  logic          mode_q;
  logic [BW-1:0] state_q, rnd_out;

  aes_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .accept(accept), .last(last), .idx(round_idx)
  );

  aes_round #(.NB(NB)) u_round (
    .state(state_q), .rkey(round_key), .inv(mode_q), .last(last), .nxt(rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      mode_q  <= 1'b0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        state_q <= data_in ^ round_key;
        mode_q  <= decrypt;
      end else if (busy) begin
        state_q <= rnd_out;
      end
      if (last) result <= rnd_out;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && round_idx == IW'(ROUNDS)) |=> done);
  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: tb/tb_aes_iter_core.sv
`timescale 1ns/1ps
module tb_aes_iter_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] data_in = '0;
  logic [127:0] round_key;
  logic [3:0]   round_idx;
  logic [127:0] result;
  logic         done;

  always #2.5 clk = ~clk;

  aes_iter_core dut (.clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .data_in(data_in), .round_key(round_key), .round_idx(round_idx),
    .result(result), .done(done));

  int n_tests = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- behavioural key generator ----
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = 0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] bsbox(input logic [7:0] x);
    logic [7:0] y = 0, b, c = 8'h63;
    for (int v = 1; v < 256; v++) if (bmul(x, 8'(v)) == 8'h01) y = 8'(v);
    for (int i = 0; i < 8; i++)
      b[i] = y[i] ^ y[(i+4)%8] ^ y[(i+5)%8] ^ y[(i+6)%8] ^ y[(i+7)%8] ^ c[i];
    return b;
  endfunction

  function automatic logic [127:0] binvmix(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++) begin
      logic [7:0] a0, a1, a2, a3;
      a0 = s[127-32*c -: 8]; a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8]; a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = bmul(a0,8'h0e)^bmul(a1,8'h0b)^bmul(a2,8'h0d)^bmul(a3,8'h09);
      o[119-32*c -: 8] = bmul(a0,8'h09)^bmul(a1,8'h0e)^bmul(a2,8'h0b)^bmul(a3,8'h0d);
      o[111-32*c -: 8] = bmul(a0,8'h0d)^bmul(a1,8'h09)^bmul(a2,8'h0e)^bmul(a3,8'h0b);
      o[103-32*c -: 8] = bmul(a0,8'h0b)^bmul(a1,8'h0d)^bmul(a2,8'h09)^bmul(a3,8'h0e);
    end
    return o;
  endfunction

  logic [127:0] ek [0:10];
  logic [127:0] dk [0:10];
  bit           key_dec = 0;

  task automatic set_key(input logic [127:0] k);
    logic [31:0] w [0:43];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {bsbox(t[31:24]), bsbox(t[23:16]), bsbox(t[15:8]), bsbox(t[7:0])};
        t[31:24] ^= rc;
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ek[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    for (int r = 0; r < 11; r++)
      dk[r] = (r == 0 || r == 10) ? ek[10-r] : binvmix(ek[10-r]);
  endtask

  always_comb begin
    if (round_idx > 4'd10) round_key = '0;
    else round_key = key_dec ? dk[round_idx] : ek[round_idx];
  end

  // ---- cycle reference model ----
  int           m_idx = 0;
  bit           m_busy = 0, m_done = 0;
  logic [127:0] m_exp, cur_exp;
  bit           m_has = 0, cur_has = 0, watching = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_idx = 0; m_done = 0;
    end else begin
      m_done = m_busy && m_idx == 10;
      if (m_busy) begin
        if (m_idx == 10) begin m_busy = 0; m_idx = 0; end
        else m_idx++;
      end else if (start) begin
        m_busy = 1; m_idx = 1; m_exp = cur_exp; m_has = cur_has;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && watching) begin
      check(round_idx == 4'(m_idx), "R2 round index", 128'(round_idx), 128'(m_idx));
      check(done == m_done, "R3 done timing", 128'(done), 128'(m_done));
      if (m_done && m_has) check(result == m_exp, "R4/R5/R7 block result", result, m_exp);
    end
  end

  logic [127:0] got;
  int           cyc;

  // call at a negedge; returns at the negedge where done is high
  task automatic run_op(input bit dec, input logic [127:0] din,
                        input bit has, input logic [127:0] exp, input bit poke);
    decrypt = dec; key_dec = dec; data_in = din; cur_has = has; cur_exp = exp;
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 40) begin
      if (poke && cyc == 4) begin
        start = 1; decrypt = ~dec; data_in = ~din;
      end else begin
        start = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; decrypt = ~dec; data_in = 128'hdead;
    check(cyc == 11, "R3 latency cycles", 128'(cyc), 128'd11);
    got = result;
  endtask

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;

  initial begin
    #(5.0 * 20000);
    check(0, "watchdog expired", 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] hold, pats [4];
    set_key(K1);
    repeat (3) @(negedge clk);
    // R1
    check(done == 0 && round_idx == 0 && result == 0, "R1 reset state",
          {result[123:0], round_idx}, 128'd0);
    rst = 0;
    @(negedge clk);
    check(done == 0 && round_idx == 0 && result == 0, "R1 after release",
          {result[123:0], round_idx}, 128'd0);
    watching = 1;

    // R4 encrypt, R6 byte order implied by the vector
    run_op(0, P1, 1, C1, 0);
    check(got == C1, "R4 encrypt vector 1", got, C1);
    repeat (2) @(negedge clk);
    hold = result;
    check(hold == C1, "R3 result held while idle", hold, C1);

    // R5 decrypt
    run_op(1, C1, 1, P1, 0);
    check(got == P1, "R5 decrypt vector 1", got, P1);
    @(negedge clk);

    // R7 start, data and direction changes while busy are ignored
    run_op(0, P1, 1, C1, 1);
    check(got == C1, "R7 busy start ignored", got, C1);
    @(negedge clk);

    // R8 back-to-back: next start in the done cycle
    set_key(K2);
    run_op(0, P2, 1, C2, 0);
    check(got == C2, "R4 encrypt vector 2", got, C2);
    run_op(1, C2, 1, P2, 0);
    check(got == P2, "R8 back-to-back decrypt", got, P2);

    // R9 round trips with assorted patterns
    pats[0] = '0; pats[1] = '1; pats[2] = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
    pats[3] = 128'h0123456789abcdeffedcba9876543210;
    for (int i = 0; i < 4; i++) begin
      logic [127:0] ct;
      repeat (i) @(negedge clk);
      run_op(0, pats[i], 0, '0, 0);
      ct = got;
      check(ct != pats[i], "R9 ciphertext differs", ct, pats[i]);
      run_op(1, ct, 1, pats[i], 0);
      check(got == pats[i], "R9 round trip", got, pats[i]);
    end

    repeat (3) @(negedge clk);
    check(round_idx == 0 && done == 0, "R2 idle after run", 128'(round_idx), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule